// File: doc/BRIEF.md
# Host-to-serial byte bridge with break generator

This block sits between an 8-bit host bus and one serial channel. The host reaches it through four address offsets. One offset moves data bytes, one reads the receive occupancy and flushes the queues, one reads the transmit occupancy and starts a line break, and one holds the frame-format configuration byte. Two FIFOs decouple the host from the serial engine. Bytes leave toward the transmitter over a valid/ready pair, and received bytes arrive as single-cycle valid pulses.

The host presents `bus_req` with an offset, a direction and write data. An access completes on the first rising edge at which `bus_wait` is low. Read data is combinational on `bus_rdata` for the offset being addressed. A write of data is stretched with `bus_wait` while the transmit FIFO is full, and also while a break is pending or active.

A break request of N does the following. It drops everything still queued for transmission. It waits for the serial engine to report that its current frame has finished. It then drives `line_brk` high, which tells the line driver to hold the line low, for N time units. Each unit is `UNIT_CLKS` system clocks.

Top module: `hostser_bridge`

## Requirements
- R1: A read of offset 0 returns the oldest received byte and removes it. When the receive FIFO is empty, the read returns 0x00 and removes nothing.
- R2: A write of offset 0 appends the byte to the transmit FIFO. While that FIFO holds DEPTH bytes, `bus_wait` is high for such a write, and the byte is appended only on the edge where `bus_wait` has dropped.
- R3: A read of offset 1 returns the receive FIFO occupancy. A read of offset 2 returns the transmit FIFO occupancy.
- R4: A write of offset 1 has these effects: with bit 0 set, it empties the receive FIFO and clears `rx_ovf`; with bit 1 set, it empties the transmit FIFO; with both bits set, it does both.
- R5: A write of offset 3 stores the byte as the configuration. A read of offset 3 returns it, and `cfg_out` always shows it.
- R6: A write of offset 2 with N > 0 empties the transmit FIFO on that edge. `line_brk` then rises on the first edge at which `tx_busy` is low, and stays high for exactly N × UNIT_CLKS cycles.
- R7: A write of 0 to offset 2 starts no break, and it ends a break that is pending or active. A nonzero write during an active break restarts the count with the new N.
- R8: While a break is pending or active, an offset 0 write sees `bus_wait` high.
- R9: `tx_valid` is high exactly when the transmit FIFO is non-empty and no break is pending or active. `tx_data` gives the bytes in write order, and one byte leaves on each edge with `tx_valid` and `tx_ready` both high.
- R10: A received byte that arrives while the receive FIFO holds DEPTH bytes is dropped and sets `rx_ovf`. `rx_ovf` stays set until a receive flush.
- R11: After reset, both FIFOs are empty, `rx_ovf` is 0, `line_brk` is 0, `tx_valid` is 0, and the configuration equals CFG_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Offset 0..3 |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| bus_wait | output | 1 | Stretches the current write |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_busy | input | 1 | Transmitter is shifting a frame |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| line_brk | output | 1 | Hold the serial line low |
| cfg_out | output | 8 | Frame-format configuration |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The bench builds the bridge with DEPTH = 4 and UNIT_CLKS = 5. With a four-entry FIFO, both FIFOs fill within a handful of cycles, so overflow, dropped bytes and the full-FIFO stall are reached often. With a five-clock unit, break lengths, pending periods and restarts take tens of cycles rather than millions. A random phase then mixes every offset with random serial-side traffic and busy periods.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_RXN  = 2'd1;
  localparam logic [1:0] OFS_TXN  = 2'd2;
  localparam logic [1:0] OFS_CFG  = 2'd3;

  typedef enum logic [1:0] {
    BRK_IDLE = 2'd0,
    BRK_PEND = 2'd1,
    BRK_ON   = 2'd2
  } brk_st_t;
endpackage

// File: rtl/hsb_fifo.sv
module hsb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0] cnt_n;
  logic          push_ok, pop_ok;

  assign full    = (cnt == FULLC);
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = cnt;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push_ok) wptr_n = step(wptr);
      if (pop_ok)  rptr_n = step(rptr);
      cnt_n = cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
      cnt  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end
endmodule

// File: rtl/hsb_brk.sv
module hsb_brk
  import hsb_pkg::*;
#(
  parameter int UNIT_CLKS = 2_000_000,
  localparam int PW = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_val,
  input  logic       tx_busy,
  output brk_st_t    st,
  output logic       line_brk
);
  localparam logic [PW-1:0] PRE_LAST = PW'(UNIT_CLKS - 1);

  brk_st_t       st_n;
  logic [7:0]    units, units_n;
  logic [PW-1:0] pre, pre_n;

  assign line_brk = (st == BRK_ON);

  always_comb begin
    st_n    = st;
    units_n = units;
    pre_n   = pre;
    if (cmd_we) begin
      if (cmd_val == 8'd0) begin
        st_n = BRK_IDLE;
      end else if (st == BRK_ON) begin
        units_n = cmd_val;
        pre_n   = '0;
      end else begin
        st_n    = BRK_PEND;
        units_n = cmd_val;
      end
    end else begin
      case (st)
        BRK_PEND: begin
          if (!tx_busy) begin
            st_n  = BRK_ON;
            pre_n = '0;
          end
        end
        BRK_ON: begin
          if (pre == PRE_LAST) begin
            pre_n = '0;
            if (units == 8'd1) st_n = BRK_IDLE;
            else               units_n = units - 8'd1;
          end else begin
            pre_n = pre + PW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= BRK_IDLE;
      units <= '0;
      pre   <= '0;
    end else begin
      st    <= st_n;
      units <= units_n;
      pre   <= pre_n;
    end
  end
endmodule

// File: rtl/hostser_bridge.sv
module hostser_bridge
  import hsb_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter int         UNIT_CLKS = 2_000_000,
  parameter logic [7:0] CFG_RST   = 8'h06,
  localparam int        CW        = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_wait,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       tx_busy,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       line_brk,
  output logic [7:0] cfg_out,
  output logic       rx_ovf
);
  logic          rst_q1, rst_sn;
  logic          acc, wr, rd;
  logic          rx_flush, tx_flush, brk_start, brk_we;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [7:0]    rx_dout, tx_dout;
  logic [7:0]    cfg_q, cfg_n;
  logic          ovf_q, ovf_n;
  brk_st_t       brk_st;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_sn <= rst_q1;
    end
  end

  assign bus_wait  = bus_req & bus_we & (bus_addr == OFS_DATA) &
                     (tx_full | (brk_st != BRK_IDLE));
  assign acc       = bus_req & ~bus_wait;
  assign wr        = acc & bus_we;
  assign rd        = acc & ~bus_we;
  assign rx_flush  = wr & (bus_addr == OFS_RXN) & bus_wdata[0];
  assign brk_we    = wr & (bus_addr == OFS_TXN);
  assign brk_start = brk_we & (bus_wdata != 8'd0);
  assign tx_flush  = (wr & (bus_addr == OFS_RXN) & bus_wdata[1]) | brk_start;
  assign tx_valid  = ~tx_empty & (brk_st == BRK_IDLE);
  assign tx_data   = tx_dout;
  assign cfg_out   = cfg_q;
  assign rx_ovf    = ovf_q;

  hsb_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_sn), .flush(rx_flush),
    .push(rx_valid), .din(rx_data),
    .pop(rd & (bus_addr == OFS_DATA)), .dout(rx_dout),
    .cnt(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  hsb_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_sn), .flush(tx_flush),
    .push(wr & (bus_addr == OFS_DATA)), .din(bus_wdata),
    .pop(tx_valid & tx_ready), .dout(tx_dout),
    .cnt(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  hsb_brk #(.UNIT_CLKS(UNIT_CLKS)) u_brk (
    .clk(clk), .rst_n(rst_sn), .cmd_we(brk_we), .cmd_val(bus_wdata),
    .tx_busy(tx_busy), .st(brk_st), .line_brk(line_brk)
  );

  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = rx_empty ? 8'h00 : rx_dout;
      OFS_RXN:  bus_rdata = 8'(rx_cnt);
      OFS_TXN:  bus_rdata = 8'(tx_cnt);
      default:  bus_rdata = cfg_q;
    endcase
  end

  always_comb begin
    cfg_n = cfg_q;
    if (wr && bus_addr == OFS_CFG) cfg_n = bus_wdata;
    ovf_n = ovf_q;
    if (rx_flush)                 ovf_n = 1'b0;
    else if (rx_valid && rx_full) ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cfg_q <= CFG_RST;
      ovf_q <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      ovf_q <= ovf_n;
    end
  end
endmodule

// File: rtl/hsb_chk.sv
module hsb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wait,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       line_brk,
  input logic       rx_ovf,
  input logic       tx_full
);
  logic acc_w;
  assign acc_w = bus_req & bus_we & ~bus_wait;

  // R2: a data write into a full transmit FIFO is held off
  a_r2_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == 2'd0 && tx_full) |-> bus_wait);

  // R8: data writes stall while the line is in break
  a_r8_hold_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == 2'd0 && line_brk) |-> bus_wait);

  // R6: nothing is offered to the transmitter during a break
  a_r6_quiet_tx: assert property (@(posedge clk) disable iff (!rst_n)
    line_brk |-> !tx_valid);

  // R9: an offered byte stays put until taken or purged
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready &&
     !(acc_w && ((bus_addr == 2'd1 && bus_wdata[1]) ||
                 (bus_addr == 2'd2 && bus_wdata != 8'd0))))
    |=> (tx_valid && $stable(tx_data)));

  // R10: overflow flag is sticky until a receive flush
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !(acc_w && bus_addr == 2'd1 && bus_wdata[0])) |=> rx_ovf);

  // R4: receive flush clears the overflow flag
  a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && bus_addr == 2'd1 && bus_wdata[0]) |=> !rx_ovf);
endmodule

bind hostser_bridge hsb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wait(bus_wait),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .line_brk(line_brk), .rx_ovf(rx_ovf), .tx_full(tx_full)
);

// File: tb/sim_hostser_bridge.sv
`timescale 1ns/1ps
module sim_hostser_bridge;
  localparam int         DEPTH = 4;
  localparam int         UNIT  = 5;
  localparam logic [7:0] CRST  = 8'h06;

  logic       clk, rst_n;
  logic       bus_req, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_wait, tx_valid, tx_ready, tx_busy, rx_valid;
  logic [7:0] tx_data, rx_data, cfg_out;
  logic       line_brk, rx_ovf;

  int nt = 0, nf = 0, cyc = 0;
  int rx_pct = 0, rdy_pct = 0, busy_pct = 0;
  bit go = 0, done = 0;

  hostser_bridge #(.DEPTH(DEPTH), .UNIT_CLKS(UNIT), .CFG_RST(CRST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_busy(tx_busy), .rx_valid(rx_valid),
    .rx_data(rx_data), .line_brk(line_brk), .cfg_out(cfg_out),
    .rx_ovf(rx_ovf)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  byte unsigned rxq[$], txq[$];
  bit           m_ovf;
  byte unsigned m_cfg;
  int           m_bst, m_units, m_pre;   // 0 idle, 1 pending, 2 on

  function automatic bit e_wait();
    return bus_req && bus_we && bus_addr == 2'd0 &&
           (txq.size() == DEPTH || m_bst != 0);
  endfunction
  function automatic bit e_txv();
    return txq.size() > 0 && m_bst == 0;
  endfunction
  function automatic byte unsigned e_rdata();
    case (bus_addr)
      2'd0:    return (rxq.size() > 0) ? rxq[0] : 8'h00;
      2'd1:    return 8'(rxq.size());
      2'd2:    return 8'(txq.size());
      default: return m_cfg;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      m_ovf = 0; m_cfg = CRST; m_bst = 0; m_units = 0; m_pre = 0;
    end else begin
      bit acc, w, txpop, rxpop, rxfull;
      acc    = bus_req && !e_wait();
      w      = acc && bus_we;
      txpop  = e_txv() && tx_ready;
      rxpop  = acc && !bus_we && bus_addr == 2'd0 && rxq.size() > 0;
      rxfull = rxq.size() == DEPTH;
      if (w && bus_addr == 2'd1 && bus_wdata[0]) begin
        rxq.delete(); m_ovf = 0;
      end else begin
        if (rxpop) void'(rxq.pop_front());
        if (rx_valid) begin
          if (rxfull) m_ovf = 1;
          else        rxq.push_back(rx_data);
        end
      end
      if (w && ((bus_addr == 2'd1 && bus_wdata[1]) ||
                (bus_addr == 2'd2 && bus_wdata != 0))) begin
        txq.delete();
      end else begin
        if (txpop) void'(txq.pop_front());
        if (w && bus_addr == 2'd0) txq.push_back(bus_wdata);
      end
      if (w && bus_addr == 2'd3) m_cfg = bus_wdata;
      if (w && bus_addr == 2'd2) begin
        if (bus_wdata == 0) m_bst = 0;
        else if (m_bst == 2) begin m_units = bus_wdata; m_pre = 0; end
        else begin m_bst = 1; m_units = bus_wdata; end
      end else if (m_bst == 1) begin
        if (!tx_busy) begin m_bst = 2; m_pre = 0; end
      end else if (m_bst == 2) begin
        if (m_pre == UNIT - 1) begin
          m_pre = 0;
          if (m_units == 1) m_bst = 0; else m_units--;
        end else m_pre++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nt++;
    if (act != exp) begin
      nf++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && go) begin
      string rt;
      case (bus_addr)
        2'd0: rt = "R1 rdata";
        2'd3: rt = "R5 rdata";
        default: rt = "R3 rdata";
      endcase
      chk(rt, bus_rdata, e_rdata());
      chk(m_bst != 0 ? "R8 wait" : "R2 wait", bus_wait, e_wait());
      chk("R9 tx_valid", tx_valid, e_txv());
      if (e_txv()) chk("R9 tx_data", tx_data, txq[0]);
      chk("R6 R7 line_brk", line_brk, m_bst == 2);
      chk("R5 cfg_out", cfg_out, m_cfg);
      chk("R10 rx_ovf", rx_ovf, m_ovf);
    end
  end

  // serial-side stimulus
  always @(negedge clk) begin
    rx_valid = ($urandom % 100) < rx_pct;
    rx_data  = 8'($urandom);
    tx_ready = ($urandom % 100) < rdy_pct;
    tx_busy  = ($urandom % 100) < busy_pct;
  end

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nt, nf);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nt++; nf++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int hi;
    rst_n = 0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    go = 1;
    #1;
    // R11 reset state
    chk("R11 rx_ovf", rx_ovf, 0);
    chk("R11 line_brk", line_brk, 0);
    chk("R11 tx_valid", tx_valid, 0);
    chk("R11 cfg_out", cfg_out, CRST);
    hrd(2'd1, v); chk("R11 rx count", v, 0);
    hrd(2'd2, v); chk("R11 tx count", v, 0);

    // R10 fill and overflow the receive FIFO
    rx_pct = 100;
    repeat (DEPTH + 3) @(negedge clk);
    rx_pct = 0;
    hrd(2'd1, v); chk("R3 rx count full", v, DEPTH);
    chk("R10 overflow set", rx_ovf, 1);
    // R1 drain, then read empty
    for (int i = 0; i < DEPTH + 1; i++) hrd(2'd0, v);
    chk("R1 empty read", v, 0);
    hrd(2'd1, v); chk("R1 count after drain", v, 0);
    hwr(2'd1, 8'h01);
    chk("R4 ovf cleared", rx_ovf, 0);

    // R2 fill transmit FIFO and stall
    rdy_pct = 0;
    for (int i = 0; i < DEPTH; i++) hwr(2'd0, 8'h10 + 8'(i));
    hrd(2'd2, v); chk("R3 tx count full", v, DEPTH);
    fork
      hwr(2'd0, 8'h5A);
      begin repeat (6) @(negedge clk); rdy_pct = 100; end
    join
    repeat (DEPTH + 3) @(negedge clk);
    hrd(2'd2, v); chk("R9 tx drained", v, 0);

    // R4 both flushes
    rdy_pct = 0; rx_pct = 100;
    hwr(2'd0, 8'h33); hwr(2'd0, 8'h44);
    rx_pct = 0;
    hwr(2'd1, 8'h03);
    hrd(2'd1, v); chk("R4 rx flushed", v, 0);
    hrd(2'd2, v); chk("R4 tx flushed", v, 0);

    // R5 configuration
    hwr(2'd3, 8'hA7);
    hrd(2'd3, v); chk("R5 cfg read", v, 8'hA7);

    // R6 plain break length
    hwr(2'd2, 8'd3);
    hi = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); #1; hi += line_brk; end
    chk("R6 break length", hi, 3 * UNIT);

    // R7 zero write: no break
    hwr(2'd2, 8'd0);
    hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); #1; hi += line_brk; end
    chk("R7 zero no break", hi, 0);

    // R6 purge and pending behind busy frame; R8 stall
    hwr(2'd0, 8'h61); hwr(2'd0, 8'h62);
    busy_pct = 100;
    hwr(2'd2, 8'd2);
    hrd(2'd2, v); chk("R6 purge on break", v, 0);
    fork
      hwr(2'd0, 8'h77);
      begin repeat (5) @(negedge clk); busy_pct = 0; end
    join
    hrd(2'd2, v); chk("R8 write after break", v, 1);
    hwr(2'd1, 8'h02);

    // R7 restart and cancel
    hwr(2'd2, 8'd4);
    repeat (6) @(negedge clk);
    hwr(2'd2, 8'd1);
    repeat (3) @(negedge clk);
    hwr(2'd2, 8'd5);
    repeat (4) @(negedge clk);
    hwr(2'd2, 8'd0);
    #1 chk("R7 cancel", line_brk, 0);

    // random mix
    rx_pct = 30; rdy_pct = 50; busy_pct = 20;
    for (int k = 0; k < 2500; k++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom);
      d = 8'($urandom);
      if (a == 2'd2) d = 8'($urandom % 3);
      if (a == 2'd1) d = ($urandom % 8 == 0) ? 8'($urandom % 4) : 8'd0;
      if ($urandom % 2) hwr(a, d); else hrd(a, v);
    end
    rx_pct = 0; busy_pct = 0;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule